// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block is the fetch and sequencing unit of a small 8-bit controller with separate program and data memories. It keeps a 10-bit word program counter, presents it as the fetch address to a 1K x 16 program memory with combinational read, and latches the returned word into an instruction register. Every instruction is one 16-bit word. While the instruction in the register executes, the next one is already being fetched, so straight-line code completes one instruction per clock.

Decoded control strobes act on the instruction held in the instruction register. The supported flow changes are a relative jump, a relative call, a return, and entry to an interrupt vector. Return addresses go onto a dedicated three-entry hardware stack, which calls and interrupts share. Relative targets wrap modulo 1024, so any offset reaches the whole program space. A taken flow change discards the word fetched in that cycle and leaves a one-cycle bubble.

Top module: `fetch_sequencer`

## Requirements
- R1: While reset is low, `imem_addr` is 0, `ir_valid` is 0, `stk_depth` is 0, and `stk_ovf` and `stk_unf` are 0. At the first rising edge after reset is released, the instruction register loads the word at address 0, `ir_pc` becomes 0 and `imem_addr` becomes 1.
- R2: In every cycle with no flow change, the next cycle shows `ir_pc` one higher (mod 1024), `ir_word` equal to the memory word at that address, and `imem_addr` equal to `ir_pc`+1 (mod 1024).
- R3: A jump taken while the instruction at address P is valid targets (P + 1 + `rel_off`) mod 1024, where `rel_off` is read as 10-bit two's complement.
- R4: Any taken flow change drives `ir_valid` to 0 for exactly one cycle, with `imem_addr` equal to the target. In the cycle after that, `ir_valid` is 1 and `ir_pc` equals the target.
- R5: A call from address P targets the same address as R3, pushes P+1 onto the return stack and increments `stk_depth`.
- R6: A return targets the top stack entry and decrements `stk_depth`. Entries come back in last-in first-out order.
- R7: A push with `stk_depth` equal to 3 discards the oldest entry and keeps `stk_depth` at 3. `stk_ovf` is 1 for exactly the next cycle.
- R8: A return with an empty stack targets address 0. `stk_unf` is 1 for exactly the next cycle and `stk_depth` stays 0.
- R9: An interrupt is taken only when `irq_req` and `irq_en` are both high and a valid instruction with no control strobe is held. It pushes `ir_pc`+1 and targets `irq_vec`. With `irq_en` low, `irq_req` has no effect.
- R10: Control strobes and interrupt requests presented during a bubble (`ir_valid` 0) are ignored. The target instruction still arrives the next cycle and the stack is unchanged.
- R11: When several strobes are asserted together, return wins over call, and call wins over jump. A pending interrupt waits until an instruction boundary that has no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| do_jmp | input | 1 | Relative jump strobe for the held instruction |
| do_call | input | 1 | Relative call strobe for the held instruction |
| do_ret | input | 1 | Return strobe for the held instruction |
| rel_off | input | 10 | Signed relative offset |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Global interrupt enable |
| irq_vec | input | 10 | Interrupt vector address |
| imem_data | input | 16 | Word read from program memory at `imem_addr` |
| imem_addr | output | 10 | Fetch address (program counter) |
| ir_word | output | 16 | Instruction register |
| ir_valid | output | 1 | Instruction register holds an instruction to execute |
| ir_pc | output | 10 | Address of the held instruction |
| stk_depth | output | 2 | Number of return stack entries in use |
| stk_ovf | output | 1 | One-cycle pulse after a push that discarded an entry |
| stk_unf | output | 1 | One-cycle pulse after a return from an empty stack |

## Verification
Two pairs of events can share a cycle. In the first, an interrupt request and a call strobe are raised together on the same valid instruction. The bench then checks that the call target is fetched first and that the request is ignored during the bubble. It also checks that the interrupt is taken at the next boundary, so that two return addresses are stacked in the order call then interrupt, and the two returns that follow unwind them in the opposite order. In the second, return and jump strobes, or call and jump strobes, are asserted together. The fetch address in the bubble and the stack depth show which strobe won.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int DEF_PC_W     = 10;
    localparam int DEF_IR_W     = 16;
    localparam int DEF_RS_DEPTH = 3;

    // Kind of flow change chosen for the current cycle
    typedef enum logic [2:0] {
        RD_NONE = 3'd0,
        RD_JMP  = 3'd1,
        RD_CALL = 3'd2,
        RD_RET  = 3'd3,
        RD_IRQ  = 3'd4
    } redir_e;

endpackage

// File: rtl/seq_arbiter.sv
module seq_arbiter
    import seq_pkg::*;
(
    input  logic   ir_valid,
    input  logic   do_jmp,
    input  logic   do_call,
    input  logic   do_ret,
    input  logic   irq_req,
    input  logic   irq_en,
    output redir_e kind
);

    logic any_strobe;

    always_comb begin
        any_strobe = do_jmp | do_call | do_ret;
        kind       = RD_NONE;
        if (ir_valid) begin
            if (do_ret) begin
                kind = RD_RET;
            end else if (do_call) begin
                kind = RD_CALL;
            end else if (do_jmp) begin
                kind = RD_JMP;
            end else if (irq_req && irq_en && !any_strobe) begin
                kind = RD_IRQ;
            end
        end
    end

endmodule

// File: rtl/seq_addr_calc.sv
module seq_addr_calc
    import seq_pkg::*;
#(
    parameter int PC_W = DEF_PC_W
) (
    input  logic [PC_W-1:0] fetch_pc,
    input  logic [PC_W-1:0] rel_off,
    input  logic [PC_W-1:0] stack_top,
    input  logic [PC_W-1:0] vector,
    input  redir_e          kind,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] target
);

    logic [PC_W-1:0] rel_target;

    always_comb begin
        // fetch_pc already points one past the held instruction
        seq_pc     = fetch_pc + PC_W'(1);
        rel_target = fetch_pc + rel_off;
        unique case (kind)
            RD_RET:  target = stack_top;
            RD_IRQ:  target = vector;
            RD_JMP,
            RD_CALL: target = rel_target;
            default: target = seq_pc;
        endcase
    end

endmodule

// File: rtl/seq_retstack.sv
module seq_retstack
    import seq_pkg::*;
#(
    parameter int PC_W  = DEF_PC_W,
    parameter int DEPTH = DEF_RS_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [PC_W-1:0]            push_val,
    output logic [PC_W-1:0]            top_val,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic                       ovf,
    output logic                       unf
);

    localparam int                CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] ent;
        logic [CNT_W-1:0]           cnt;
        logic                       ovf;
        logic                       unf;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        s_d.unf = 1'b0;
        if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                s_d.ent[i] = s_q.ent[i-1];
            end
            s_d.ent[0] = push_val;
            if (s_q.cnt == FULL) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                s_d.ent[i] = s_q.ent[i+1];
            end
            s_d.ent[DEPTH-1] = '0;
            if (s_q.cnt == '0) begin
                s_d.unf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign top_val = (s_q.cnt == '0) ? '0 : s_q.ent[0];
    assign depth   = s_q.cnt;
    assign ovf     = s_q.ovf;
    assign unf     = s_q.unf;

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.cnt == FULL) |=> (ovf && s_q.cnt == FULL));

    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt == '0) |=> (unf && s_q.cnt == '0 && top_val == '0));

    p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    p_pushpop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W     = DEF_PC_W,
    parameter int IR_W     = DEF_IR_W,
    parameter int RS_DEPTH = DEF_RS_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          do_jmp,
    input  logic                          do_call,
    input  logic                          do_ret,
    input  logic [PC_W-1:0]               rel_off,
    input  logic                          irq_req,
    input  logic                          irq_en,
    input  logic [PC_W-1:0]               irq_vec,
    input  logic [IR_W-1:0]               imem_data,
    output logic [PC_W-1:0]               imem_addr,
    output logic [IR_W-1:0]               ir_word,
    output logic                          ir_valid,
    output logic [PC_W-1:0]               ir_pc,
    output logic [$clog2(RS_DEPTH+1)-1:0] stk_depth,
    output logic                          stk_ovf,
    output logic                          stk_unf
);

    localparam int CNT_W = $clog2(RS_DEPTH + 1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] ir_pc;
        logic [IR_W-1:0] ir;
        logic            ir_valid;
    } fetch_st_t;

    fetch_st_t       f_d, f_q;
    redir_e          kind;
    logic            redirect;
    logic            push, pop;
    logic [PC_W-1:0] seq_pc, target, stack_top;
    logic [CNT_W-1:0] depth_w;
    logic            ovf_w, unf_w;

    seq_arbiter u_arb (
        .ir_valid (f_q.ir_valid),
        .do_jmp   (do_jmp),
        .do_call  (do_call),
        .do_ret   (do_ret),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .kind     (kind)
    );

    seq_addr_calc #(.PC_W(PC_W)) u_addr (
        .fetch_pc  (f_q.pc),
        .rel_off   (rel_off),
        .stack_top (stack_top),
        .vector    (irq_vec),
        .kind      (kind),
        .seq_pc    (seq_pc),
        .target    (target)
    );

    seq_retstack #(.PC_W(PC_W), .DEPTH(RS_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (f_q.pc),
        .top_val  (stack_top),
        .depth    (depth_w),
        .ovf      (ovf_w),
        .unf      (unf_w)
    );

    always_comb begin
        redirect = (kind != RD_NONE);
        push     = (kind == RD_CALL) || (kind == RD_IRQ);
        pop      = (kind == RD_RET);
        f_d      = f_q;
        if (redirect) begin
            // drop the word fetched this cycle, refetch from target
            f_d.pc       = target;
            f_d.ir_valid = 1'b0;
        end else begin
            f_d.pc       = seq_pc;
            f_d.ir       = imem_data;
            f_d.ir_pc    = f_q.pc;
            f_d.ir_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign imem_addr = f_q.pc;
    assign ir_word   = f_q.ir;
    assign ir_valid  = f_q.ir_valid;
    assign ir_pc     = f_q.ir_pc;
    assign stk_depth = depth_w;
    assign stk_ovf   = ovf_w;
    assign stk_unf   = unf_w;

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !ir_valid);

    p_single_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_valid |=> ir_valid);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && !redirect) |=> (ir_pc == PC_W'($past(ir_pc) + PC_W'(1))));

    p_prefetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_valid |-> (imem_addr == PC_W'(ir_pc + PC_W'(1))));

    p_irq_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RD_IRQ) |=> (imem_addr == $past(irq_vec)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !do_jmp && !do_call && !do_ret) |-> !redirect);

    p_ret_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RD_RET) |=> (imem_addr == $past(stack_top)));

endmodule

// File: tb/sim_fetch_sequencer.sv
`timescale 1ns/1ps
module sim_fetch_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        do_jmp, do_call, do_ret, irq_req, irq_en;
    logic [9:0]  rel_off, irq_vec, imem_addr, ir_pc;
    logic [15:0] imem_data, ir_word;
    logic        ir_valid, stk_ovf, stk_unf;
    logic [1:0]  stk_depth;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int ms[3];
    int md = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] word_at(logic [9:0] a);
        return {~a[5:0], a};
    endfunction

    assign imem_data = word_at(imem_addr);

    fetch_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .do_jmp(do_jmp), .do_call(do_call),
        .do_ret(do_ret), .rel_off(rel_off), .irq_req(irq_req),
        .irq_en(irq_en), .irq_vec(irq_vec), .imem_data(imem_data),
        .imem_addr(imem_addr), .ir_word(ir_word), .ir_valid(ir_valid),
        .ir_pc(ir_pc), .stk_depth(stk_depth), .stk_ovf(stk_ovf),
        .stk_unf(stk_unf)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic void m_push(int v);
        ms[2] = ms[1];
        ms[1] = ms[0];
        ms[0] = v;
        if (md < 3) md++;
    endfunction

    function automatic int m_pop();
        int v;
        if (md == 0) return 0;
        v = ms[0];
        ms[0] = ms[1];
        ms[1] = ms[2];
        md--;
        return v;
    endfunction

    task automatic run_seq(int n);
        for (int i = 0; i < n; i++) begin
            int prev = ir_pc;
            tick();
            chk("R2 valid", ir_valid, 1);
            chk("R2 pc", ir_pc, (prev + 1) & 1023);
            chk("R2 word", ir_word, word_at(10'((prev + 1) & 1023)));
            chk("R2 fetch", imem_addr, (prev + 2) & 1023);
        end
    endtask

    task automatic land(string req, int exp);
        tick();
        chk({req, " R4 refill"}, ir_valid, 1);
        chk({req, " R4 pc"}, ir_pc, exp);
        chk({req, " R4 word"}, ir_word, word_at(10'(exp)));
    endtask

    task automatic jump(int off);
        int exp = (ir_pc + 1 + off) & 1023;
        do_jmp = 1; rel_off = 10'(off);
        tick();
        do_jmp = 0;
        chk("R4 bubble", ir_valid, 0);
        chk("R3 target", imem_addr, exp);
        land("R3", exp);
    endtask

    task automatic call(int off);
        int exp  = (ir_pc + 1 + off) & 1023;
        int full = (md == 3);
        m_push((ir_pc + 1) & 1023);
        do_call = 1; rel_off = 10'(off);
        tick();
        do_call = 0;
        chk("R5 bubble", ir_valid, 0);
        chk("R5 target", imem_addr, exp);
        chk("R5 depth", stk_depth, md);
        chk("R7 ovf pulse", stk_ovf, full);
        land("R5", exp);
        chk("R7 ovf clear", stk_ovf, 0);
    endtask

    task automatic ret();
        int empty = (md == 0);
        int exp   = m_pop();
        do_ret = 1;
        tick();
        do_ret = 0;
        chk("R6 target", imem_addr, exp);
        chk("R6 depth", stk_depth, md);
        chk("R8 unf pulse", stk_unf, empty);
        land("R6", exp);
        chk("R8 unf clear", stk_unf, 0);
    endtask

    initial begin
        rst_n = 0; do_jmp = 0; do_call = 0; do_ret = 0;
        irq_req = 0; irq_en = 0; rel_off = '0; irq_vec = '0;
        repeat (3) tick();
        chk("R1 addr", imem_addr, 0);
        chk("R1 valid", ir_valid, 0);
        chk("R1 depth", stk_depth, 0);
        chk("R1 ovf", stk_ovf, 0);
        chk("R1 unf", stk_unf, 0);
        rst_n = 1;
        tick();
        chk("R1 first valid", ir_valid, 1);
        chk("R1 first pc", ir_pc, 0);
        chk("R1 first word", ir_word, word_at(10'd0));
        chk("R1 first fetch", imem_addr, 1);
        run_seq(5);

        // R3: every offset
        for (int k = 0; k < 1024; k++) jump(k);

        // R2: wrap from 1023 to 0
        jump((1021 - (ir_pc + 1)) & 1023);
        run_seq(5);

        // R5 / R6 basic nesting
        call(37);
        call(1000);
        run_seq(2);
        ret();
        ret();

        // R7 overflow: four pushes into three entries
        call(100); call(200); call(300); call(400);
        ret(); ret(); ret();
        // R8 underflow
        ret();
        run_seq(2);

        // R9: request masked by enable
        begin
            irq_req = 1; irq_en = 0; irq_vec = 10'd800;
            run_seq(4);
            chk("R9 masked depth", stk_depth, 0);
            irq_en = 1;
            m_push((ir_pc + 1) & 1023);
            tick();
            irq_req = 0;
            chk("R9 bubble", ir_valid, 0);
            chk("R9 vector", imem_addr, 800);
            chk("R9 depth", stk_depth, md);
            land("R9", 800);
            run_seq(3);
            ret();
        end

        // R9 vector sweep
        for (int v = 0; v < 1024; v += 73) begin
            irq_req = 1; irq_vec = 10'(v);
            m_push((ir_pc + 1) & 1023);
            tick();
            irq_req = 0;
            chk("R9 sweep vector", imem_addr, v);
            land("R9", v);
            ret();
        end

        // R11: call and interrupt in the same cycle
        begin
            int t;
            t = (ir_pc + 1 + 50) & 1023;
            m_push((ir_pc + 1) & 1023);
            irq_req = 1; irq_vec = 10'd900;
            do_call = 1; rel_off = 10'd50;
            tick();
            do_call = 0;
            chk("R11 call first", imem_addr, t);
            chk("R11 depth one", stk_depth, 1);
            // R10: request held through the bubble is not taken
            tick();
            chk("R10 no irq in bubble", ir_pc, t);
            chk("R10 valid", ir_valid, 1);
            m_push((t + 1) & 1023);
            tick();
            irq_req = 0;
            chk("R11 irq next", imem_addr, 900);
            chk("R11 depth two", stk_depth, 2);
            land("R11", 900);
            ret();
            ret();
        end

        // R10: strobes during bubble ignored
        begin
            int t;
            t = (ir_pc + 1 + 5) & 1023;
            do_jmp = 1; rel_off = 10'd5;
            tick();
            do_jmp = 1; do_call = 1; rel_off = 10'd300;
            tick();
            do_jmp = 0; do_call = 0;
            chk("R10 pc", ir_pc, t);
            chk("R10 valid", ir_valid, 1);
            chk("R10 depth", stk_depth, 0);
        end

        // R11: return beats jump, call beats jump
        begin
            int t;
            call(20);
            t = m_pop();
            do_ret = 1; do_jmp = 1; rel_off = 10'd400;
            tick();
            do_ret = 0; do_jmp = 0;
            chk("R11 ret over jmp", imem_addr, t);
            chk("R11 ret depth", stk_depth, 0);
            land("R11", t);
            t = (ir_pc + 1 + 9) & 1023;
            m_push((ir_pc + 1) & 1023);
            do_call = 1; do_jmp = 1; rel_off = 10'd9;
            tick();
            do_call = 0; do_jmp = 0;
            chk("R11 call over jmp", stk_depth, 1);
            land("R11", t);
            ret();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule